// File: doc/BRIEF.md
# Shared-Window Multithread Retire Arbiter

This block keeps the in-flight window of eight hardware threads in one shared pool of reorder slots and retires each thread's instructions strictly in the order they were allocated. Each slot holds an opaque tag, a done bit, the owning thread and a link to the next slot of the same thread. Each thread has a head pointer and a tail pointer, so a thread can hold any number of slots up to the pool size.

The front end allocates up to two instructions of one thread per cycle. It receives the indices of the slots it was given and uses them to mark instructions done through two completion ports. Every cycle a retire arbiter looks at the threads whose oldest slot is done. It picks the one that retired least recently and retires one or two of that thread's oldest instructions. Three per-thread event inputs (a last-level cache miss, a load/store timeout and an I/O access) each flush a thread and release all of its slots at once.

Top module: `mt_retire_arb`

## Requirements
- R1: After reset all slots are free. No retire is reported, `alloc_stall` is low, and the first allocation receives slot indices 0 and 1.
- R2: When `alloc_n` is 1, or when it is 2 or 3 (both meaning two), and the request is accepted, the instructions take the lowest free slot index and, for a pair, the next lowest free slot index. These are shown on `alloc_idx0` and `alloc_idx1` in the same cycle. Both instructions belong to `alloc_tid`, and `alloc_tag0` is the older of the two.
- R3: `alloc_stall` is high exactly when fewer than two slots are free. While it is high, any allocation request is ignored.
- R4: A completion port whose valid bit is set marks the addressed slot done at the next edge if that slot is in use. A completion to a free slot has no effect.
- R5: A thread can retire only when its oldest slot is done. Its instructions retire in allocation order, and the oldest tag is shown on `cm_tag0`.
- R6: At most two instructions retire per cycle, and both come from `cm_tid`. The second is retired (`cm_cnt` = 2, tag on `cm_tag1`) only if the thread's next slot in order is also done.
- R7: Among eligible threads, the winner is the one whose last retire is oldest. After reset, threads that have never retired rank by ascending thread number. A thread that retires becomes the most recent.
- R8: A set bit for thread t in any of `ev_l3miss`, `ev_lstmo` or `ev_io` releases every slot held by t at the next edge. In that cycle t does not retire, and an allocation for t is dropped.
- R9: Slots freed by a retire or a flush become available for allocation from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_n | input | 2 | Number of instructions to allocate (0, 1, 2; 3 acts as 2) |
| alloc_tid | input | 3 | Thread of the allocated instructions |
| alloc_tag0 | input | 16 | Tag of the older allocated instruction |
| alloc_tag1 | input | 16 | Tag of the younger allocated instruction |
| alloc_stall | output | 1 | Fewer than two free slots; allocation refused |
| alloc_idx0 | output | 7 | Slot given to the older instruction |
| alloc_idx1 | output | 7 | Slot given to the younger instruction |
| cmp_vld | input | 2 | Valid bit of each completion port |
| cmp_idx0 | input | 7 | Slot completed by port 0 |
| cmp_idx1 | input | 7 | Slot completed by port 1 |
| ev_l3miss | input | 8 | Per-thread flush on last-level cache miss |
| ev_lstmo | input | 8 | Per-thread flush on load/store timeout |
| ev_io | input | 8 | Per-thread flush on I/O access |
| cm_vld | output | 1 | A retire happens this cycle |
| cm_tid | output | 3 | Thread that retires |
| cm_cnt | output | 2 | Instructions retired (0, 1 or 2) |
| cm_tag0 | output | 16 | Tag of the older retired instruction |
| cm_tag1 | output | 16 | Tag of the younger retired instruction, zero when only one retires |

## Verification
The retire outputs and the allocation indices are combinational over the registered state, so they are due in the same cycle as the state that produces them. A completion, allocation or flush applied before an edge can therefore change the retire outputs only in the cycle after that edge. The bench drives inputs at the falling edge, compares the outputs one time unit later against a model that holds the state as it stood before the coming rising edge, and then advances the model by exactly one edge. Because of this, every result is checked in the cycle it is due, and a result that arrives a cycle early or late is reported.

// File: rtl/mt_retire_arb.sv
module mt_retire_arb #(
  parameter int NTHR  = 8,
  parameter int DEPTH = 128,
  parameter int TAGW  = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               alloc_n,
  input  logic [$clog2(NTHR)-1:0]  alloc_tid,
  input  logic [TAGW-1:0]          alloc_tag0,
  input  logic [TAGW-1:0]          alloc_tag1,
  output logic                     alloc_stall,
  output logic [$clog2(DEPTH)-1:0] alloc_idx0,
  output logic [$clog2(DEPTH)-1:0] alloc_idx1,
  input  logic [1:0]               cmp_vld,
  input  logic [$clog2(DEPTH)-1:0] cmp_idx0,
  input  logic [$clog2(DEPTH)-1:0] cmp_idx1,
  input  logic [NTHR-1:0]          ev_l3miss,
  input  logic [NTHR-1:0]          ev_lstmo,
  input  logic [NTHR-1:0]          ev_io,
  output logic                     cm_vld,
  output logic [$clog2(NTHR)-1:0]  cm_tid,
  output logic [1:0]               cm_cnt,
  output logic [TAGW-1:0]          cm_tag0,
  output logic [TAGW-1:0]          cm_tag1
);
  localparam int TW = $clog2(NTHR);
  localparam int IW = $clog2(DEPTH);

  logic [DEPTH-1:0] vld, dn;
  logic [IW-1:0]    nxt [DEPTH];
  logic [TW-1:0]    own [DEPTH];
  logic [TAGW-1:0]  tag [DEPTH];
  logic [IW-1:0]    hd  [NTHR];
  logic [IW-1:0]    tl  [NTHR];
  logic [TW-1:0]    rank [NTHR];
  logic [NTHR-1:0]  busy;

  wire [NTHR-1:0] flush = ev_l3miss | ev_lstmo | ev_io;

  logic [IW-1:0] f0, f1;
  logic h0, h1;
  always_comb begin
    f0 = '0; f1 = '0; h0 = 1'b0; h1 = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!vld[i]) begin
        if (!h0) begin f0 = IW'(i); h0 = 1'b1; end
        else if (!h1) begin f1 = IW'(i); h1 = 1'b1; end
      end
    end
  end

  assign alloc_stall = !h1;
  assign alloc_idx0  = f0;
  assign alloc_idx1  = f1;

  wire           two      = alloc_n[1];
  wire           alloc_go = !alloc_stall && (alloc_n != 2'd0) && !flush[alloc_tid];
  wire [IW-1:0]  last_a   = two ? f1 : f0;

  logic [NTHR-1:0] elig;
  logic [TW-1:0]   win;
  logic            found;
  always_comb begin
    win = '0; found = 1'b0;
    for (int t = 0; t < NTHR; t++) begin
      elig[t] = busy[t] && dn[hd[t]] && !flush[t];
      if (elig[t] && (!found || rank[t] < rank[win])) begin
        win = TW'(t); found = 1'b1;
      end
    end
  end

  wire [IW-1:0] ci0    = hd[win];
  wire [IW-1:0] ci1    = nxt[ci0];
  wire          second = found && (ci0 != tl[win]) && dn[ci1];
  wire [IW-1:0] last_c = second ? ci1 : ci0;
  wire          empties = (last_c == tl[win]);

  assign cm_vld  = found;
  assign cm_tid  = win;
  assign cm_cnt  = !found ? 2'd0 : (second ? 2'd2 : 2'd1);
  assign cm_tag0 = found ? tag[ci0] : '0;
  assign cm_tag1 = second ? tag[ci1] : '0;

  logic [NTHR-1:0] hit, rel_empty;
  always_comb begin
    for (int t = 0; t < NTHR; t++) begin
      hit[t]       = found && (win == TW'(t));
      rel_empty[t] = !busy[t] || (hit[t] && empties);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld  <= '0;
      dn   <= '0;
      busy <= '0;
      for (int t = 0; t < NTHR; t++) rank[t] <= TW'(t);
    end else begin
      if (cmp_vld[0] && vld[cmp_idx0]) dn[cmp_idx0] <= 1'b1;
      if (cmp_vld[1] && vld[cmp_idx1]) dn[cmp_idx1] <= 1'b1;

      if (found) begin
        vld[ci0] <= 1'b0;
        if (second) vld[ci1] <= 1'b0;
        for (int t = 0; t < NTHR; t++)
          if (rank[t] > rank[win]) rank[t] <= rank[t] - 1'b1;
        rank[win] <= TW'(NTHR - 1);
      end

      for (int i = 0; i < DEPTH; i++)
        if (vld[i] && flush[own[i]]) vld[i] <= 1'b0;

      for (int t = 0; t < NTHR; t++) begin
        if (flush[t]) begin
          busy[t] <= 1'b0;
        end else begin
          if (hit[t] && !empties) hd[t] <= nxt[last_c];
          if (alloc_go && alloc_tid == TW'(t)) begin
            if (rel_empty[t]) hd[t] <= f0;
            else nxt[tl[t]] <= f0;
            tl[t]   <= last_a;
            busy[t] <= 1'b1;
          end else if (rel_empty[t]) begin
            busy[t] <= 1'b0;
          end
        end
      end

      if (alloc_go) begin
        vld[f0] <= 1'b1; dn[f0] <= 1'b0; own[f0] <= alloc_tid; tag[f0] <= alloc_tag0;
        if (two) begin
          nxt[f0] <= f1;
          vld[f1] <= 1'b1; dn[f1] <= 1'b0; own[f1] <= alloc_tid; tag[f1] <= alloc_tag1;
        end
      end
    end
  end

  p_alloc_taken_r2: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_go |=> vld[$past(f0)] && own[$past(f0)] == $past(alloc_tid));

  p_stall_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_stall && !found && flush == '0 |=> $countones(vld) == $past($countones(vld)));

  p_head_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cm_vld |-> vld[ci0] && dn[ci0] && own[ci0] == cm_tid);

  p_pair_thread_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cm_cnt == 2'd2 |-> vld[ci1] && dn[ci1] && own[ci1] == cm_tid);

  p_lrc_move_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cm_vld |=> rank[$past(cm_tid)] == TW'(NTHR - 1));

  p_no_flushed_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cm_vld |-> !flush[cm_tid]);

  p_flush_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flush != '0) |=> (busy & $past(flush)) == '0);
endmodule

// File: tb/mt_retire_arb_tb.sv
module mt_retire_arb_tb;
  localparam int CLK = 10;
  localparam int NT = 8;
  localparam int DP = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] alloc_n = '0;
  logic [2:0] alloc_tid = '0;
  logic [15:0] alloc_tag0 = '0, alloc_tag1 = '0;
  logic alloc_stall;
  logic [3:0] alloc_idx0, alloc_idx1;
  logic [1:0] cmp_vld = '0;
  logic [3:0] cmp_idx0 = '0, cmp_idx1 = '0;
  logic [7:0] ev_l3miss = '0, ev_lstmo = '0, ev_io = '0;
  logic cm_vld;
  logic [2:0] cm_tid;
  logic [1:0] cm_cnt;
  logic [15:0] cm_tag0, cm_tag1;

  mt_retire_arb #(.NTHR(NT), .DEPTH(DP), .TAGW(16)) u_dut (.*);

  always #(CLK/2) clk = ~clk;

  int checks = 0, errors = 0;
  bit mv[DP], md[DP];
  logic [15:0] mt[DP];
  int q[NT][DP];
  int qn[NT];
  int rk[NT];
  int seq = 0;

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(int t);
    seq++;
    return {t[3:0], seq[11:0]};
  endfunction

  task automatic idle();
    alloc_n = 0; cmp_vld = 0; ev_l3miss = 0; ev_lstmo = 0; ev_io = 0;
  endtask

  task automatic step();
    bit [7:0] fl;
    int ew, ecnt, e0, e1, nfree, n;
    bit found;
    #1;
    fl = ev_l3miss | ev_lstmo | ev_io;
    found = 0; ew = 0; ecnt = 0;
    for (int t = 0; t < NT; t++)
      if (qn[t] > 0 && md[q[t][0]] && !fl[t] && (!found || rk[t] < rk[ew])) begin
        found = 1; ew = t;
      end
    if (found) ecnt = (qn[ew] >= 2 && md[q[ew][1]]) ? 2 : 1;
    nfree = 0; e0 = 0; e1 = 0;
    for (int i = 0; i < DP; i++)
      if (!mv[i]) begin
        if (nfree == 0) e0 = i; else if (nfree == 1) e1 = i;
        nfree++;
      end
    chk(alloc_stall == (nfree < 2), "R3 stall", alloc_stall, nfree < 2);
    chk(cm_vld == found, "R5 retire valid", cm_vld, found);
    if (found && cm_vld) begin
      chk(cm_tid == ew, "R7 least recent winner", cm_tid, ew);
      chk(cm_cnt == ecnt, "R6 retire count", cm_cnt, ecnt);
      chk(cm_tag0 == mt[q[ew][0]], "R5 program order tag0", cm_tag0, mt[q[ew][0]]);
      if (ecnt == 2) begin
        chk(cm_tag1 == mt[q[ew][1]], "R6 second tag", cm_tag1, mt[q[ew][1]]);
        chk(cm_tag1[15:12] == cm_tag0[15:12], "R6 same thread pair", cm_tag1, cm_tag0);
      end
    end
    n = (alloc_n >= 2) ? 2 : alloc_n;
    if (nfree >= 2 && n > 0) begin
      chk(alloc_idx0 == e0, "R2 R9 slot index0", alloc_idx0, e0);
      if (n == 2) chk(alloc_idx1 == e1, "R2 R9 slot index1", alloc_idx1, e1);
    end
    // R4: completion only lands on a slot in use
    if (cmp_vld[0] && mv[cmp_idx0]) md[cmp_idx0] = 1;
    if (cmp_vld[1] && mv[cmp_idx1]) md[cmp_idx1] = 1;
    if (found) begin
      for (int k = 0; k < ecnt; k++) begin
        mv[q[ew][0]] = 0;
        for (int j = 0; j < DP - 1; j++) q[ew][j] = q[ew][j+1];
        qn[ew]--;
      end
      for (int t = 0; t < NT; t++) if (rk[t] > rk[ew]) rk[t]--;
      rk[ew] = NT - 1;
    end
    for (int t = 0; t < NT; t++)
      if (fl[t]) begin
        for (int j = 0; j < qn[t]; j++) mv[q[t][j]] = 0;
        qn[t] = 0;
      end
    if (nfree >= 2 && n > 0 && !fl[alloc_tid]) begin
      mv[e0] = 1; md[e0] = 0; mt[e0] = alloc_tag0;
      q[alloc_tid][qn[alloc_tid]] = e0; qn[alloc_tid]++;
      if (n == 2) begin
        mv[e1] = 1; md[e1] = 0; mt[e1] = alloc_tag1;
        q[alloc_tid][qn[alloc_tid]] = e1; qn[alloc_tid]++;
      end
    end
    @(negedge clk);
  endtask

  task automatic alloc(int t, int n);
    alloc_n = 2'(n); alloc_tid = 3'(t);
    alloc_tag0 = mk(t); alloc_tag1 = mk(t);
  endtask

  initial begin
    #(CLK * 200000);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int t = 0; t < NT; t++) begin qn[t] = 0; rk[t] = t; end
    for (int i = 0; i < DP; i++) begin mv[i] = 0; md[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    chk(cm_vld == 0, "R1 no retire", cm_vld, 0);
    chk(alloc_stall == 0, "R1 no stall", alloc_stall, 0);
    chk(alloc_idx0 == 0 && alloc_idx1 == 1, "R1 first slots", {alloc_idx0, alloc_idx1}, 8'h01);
    @(negedge clk);

    // R5/R6: younger done alone must not retire, then both go together
    alloc(3, 2); step(); idle();
    cmp_vld = 2'b01; cmp_idx0 = 4'd1; step(); idle();
    step();
    cmp_vld = 2'b01; cmp_idx0 = 4'd0; step(); idle();
    step(); step();

    // R7: several threads ready at once
    alloc(5, 1); step(); alloc(1, 1); step(); alloc(2, 2); step(); alloc(3, 1); step(); idle();
    for (int i = 0; i < 5; i++) begin
      cmp_vld = 2'b11; cmp_idx0 = 4'(i); cmp_idx1 = 4'(i + 5); step();
    end
    idle();
    repeat (6) step();

    // R4: completion to a free slot is ignored, that slot later allocates not done
    cmp_vld = 2'b10; cmp_idx1 = 4'd0; step(); idle();
    alloc(6, 1); step(); idle(); repeat (2) step();
    cmp_vld = 2'b01; cmp_idx0 = 4'd0; step(); idle(); step();

    // R3: fill and stall
    for (int i = 0; i < 10; i++) begin alloc(0, 2); step(); end
    idle();
    cmp_vld = 2'b11; cmp_idx0 = 4'd0; cmp_idx1 = 4'd1; step(); idle();
    alloc(4, 2); step(); idle();
    // R8: flush by each event kind
    ev_io[0] = 1'b1; alloc(0, 1); step(); idle();
    alloc(4, 2); step(); alloc(7, 2); step(); idle();
    ev_l3miss[4] = 1'b1; step(); idle();
    ev_lstmo[7] = 1'b1; cmp_vld = 2'b11; cmp_idx0 = alloc_idx0; cmp_idx1 = 4'd3; step(); idle();
    repeat (3) step();

    // sweep
    for (int c = 0; c < 6000; c++) begin
      int r;
      r = $urandom % 10;
      if (r < 6) alloc($urandom % NT, (r < 3) ? 2 : 1); else alloc_n = 0;
      cmp_vld = 2'($urandom);
      cmp_idx0 = 4'($urandom); cmp_idx1 = 4'($urandom);
      ev_l3miss = 0; ev_lstmo = 0; ev_io = 0;
      if ($urandom % 50 == 0) begin
        case ($urandom % 3)
          0: ev_l3miss[$urandom % NT] = 1'b1;
          1: ev_lstmo[$urandom % NT] = 1'b1;
          default: ev_io[$urandom % NT] = 1'b1;
        endcase
      end
      step();
    end
    idle();
    for (int c = 0; c < 40; c++) begin
      cmp_vld = 2'b11; cmp_idx0 = 4'(c % DP); cmp_idx1 = 4'((c + 8) % DP); step();
    end
    idle(); repeat (10) step();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule